// File: doc/BRIEF.md
# Strided and Gathering Vector Load Unit over Interleaved Banks

This block reads a vector of words from a memory split across several word-interleaved banks. A request gives a starting word address, a mode, a length and, depending on the mode, a constant step or a list of per-element offsets. The unit produces one word address per element and sends each one to the bank picked by the low address bits. If that bank is still occupied by an earlier access, the unit waits. The elements leave the block strictly in ascending element order, each with a valid strobe and its element number.

Every bank is a plain array that cannot overlap accesses. Once it accepts a read it stays occupied for a fixed number of clocks. The sustained rate therefore depends on how the step relates to the number of banks. Consecutive addresses, and steps that share no factor with the bank count, stream one word per clock whenever there are at least as many banks as the latency. Even steps land on fewer banks and leave gaps in the output. Bank contents are preset at reset from a fixed formula, so the block can be used and checked without a write path.

Top module: `banked_vload`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy`, `out_valid` and `done` are 0.
- R2: `start` is accepted only on an edge where `busy` is 0, and `busy` is 1 after that edge. A `start` seen while `busy` is 1 is ignored and does not change the running request's outputs.
- R3: A word address `a` maps to bank `a mod NB` and row `a / NB`. The word stored at `a` is the low DW bits of `a*40503 + 4660`.
- R4: In mode 0, and in the spare mode 3, element `i` reads address `(base + i) mod 2^AW`. The `stride` input is ignored.
- R5: In mode 1, element `i` reads address `(base + i*stride) mod 2^AW`.
- R6: In mode 2, element `i` reads address `(base + index_list[i*AW +: AW]) mod 2^AW`. The offset list is captured when the request is accepted.
- R7: Element 0 can be issued at the first edge after the accepting edge. Each later element is issued at the earliest edge after the previous issue at which its bank has had at least LAT clocks since its own last issue. The element's word appears on the outputs LAT+1 cycles after its issue edge.
- R8: A mode-0 request with NB >= LAT delivers its elements in consecutive cycles. The first one appears LAT+2 cycles after the accepting edge.
- R9: A mode-1 step that is odd for NB=8 gives the same gap-free stream as R8. A step of 2 leaves gaps. A step of 8 delivers one element every LAT cycles.
- R10: `out_idx` counts 0, 1, 2, ... across the valid outputs of a request.
- R11: `done` is a one-cycle pulse in the cycle of the last element's `out_valid`, and `busy` is 0 in that cycle.
- R12: A request with `len` 0 pulses `done` one cycle after the accepting edge and never raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken when `busy` is 0 |
| mode | input | 2 | 0 consecutive, 1 constant step, 2 offset list, 3 as 0 |
| base | input | AW | Starting word address |
| stride | input | AW | Step between elements in mode 1 |
| len | input | $clog2(MAXVL+1) | Number of elements, 0 to MAXVL |
| index_list | input | MAXVL*AW | Per-element offsets for mode 2, element i at bits [i*AW +: AW] |
| busy | output | 1 | A request is in progress |
| out_valid | output | 1 | An element word is presented |
| out_idx | output | $clog2(MAXVL) | Element number of the presented word |
| out_data | output | DW | Element word |
| done | output | 1 | Last element of the request, or empty request finished |

## Verification
The hardest situation to reach is a long run of stalls in which a bank is wanted again before its busy window has closed. Issue then pauses while earlier results are still draining. The stimulus builds this with steps of 2 and 8, and with offset lists that revisit the same bank back to back. A behavioural schedule of per-bank free times predicts the exact cycle of every output. A second `start` arriving mid-request, and an address run that wraps past the top of the address space, cover the ignore rule and the modular address arithmetic.

// File: rtl/vload_pkg.sv
// Shared definitions for the banked vector load unit.
// Assumes: word addresses; memory contents fixed at reset.
package vload_pkg;

    // Access pattern selector carried by each request.
    typedef enum logic [1:0] {
        VM_UNIT   = 2'd0,
        VM_STRIDE = 2'd1,
        VM_GATHER = 2'd2,
        VM_SPARE  = 2'd3
    } vmode_e;

    // Preset value of the word at a given address (truncated by the caller).
    function automatic logic [31:0] cell_value(input logic [31:0] waddr);
        return waddr * 32'd40503 + 32'd4660;
    endfunction

endpackage

// File: rtl/vload_bank.sv
// One unpipelined memory bank. It holds ROWS words, accepts a read only
// when idle, and returns the word LAT cycles after acceptance together
// with the element tag it was given.
// Assumes: LAT >= 1; the caller issues only while ready is high.
module vload_bank
    import vload_pkg::*;
#(
    parameter int LAT     = 6,
    parameter int BW      = 3,
    parameter int RW      = 5,
    parameter int DW      = 16,
    parameter int TW      = 4,
    parameter int BANK_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [RW-1:0] row,
    input  logic [TW-1:0] tag_in,
    output logic          ready,
    output logic          ret_valid,
    output logic [TW-1:0] ret_tag,
    output logic [DW-1:0] ret_data
);

    localparam int ROWS = 1 << RW;
    localparam int CNTW = $clog2(LAT + 1);

    logic [DW-1:0]   mem_q [ROWS];
    logic [CNTW-1:0] cnt_q;
    logic [DW-1:0]   hold_q;
    logic [TW-1:0]   htag_q;

    // The bank may take a new read on the edge where the current one finishes.
    assign ready = (cnt_q <= CNTW'(1));

    // Preset storage from the address formula; never written afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= DW'(cell_value(32'((r << BW) + BANK_ID)));
            end
        end
    end

    // Busy countdown and capture of the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
            htag_q <= '0;
        end else if (issue) begin
            cnt_q  <= CNTW'(LAT);
            hold_q <= mem_q[row];
            htag_q <= tag_in;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNTW'(1);
        end
    end

    // Present the finished word for one cycle when the countdown expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
            ret_tag   <= '0;
            ret_data  <= '0;
        end else begin
            ret_valid <= (cnt_q == CNTW'(1));
            if (cnt_q == CNTW'(1)) begin
                ret_tag  <= htag_q;
                ret_data <= hold_q;
            end
        end
    end

endmodule

// File: rtl/vload_agen.sv
// Address generator and issue control. It latches a request, forms the
// address of the next element (running sum for consecutive and stepped
// modes, base plus captured offset for the list mode) and issues it to
// its bank as soon as that bank is ready, at most one element per cycle.
// Assumes: a new accept arrives only after the previous request is done.
module vload_agen
    import vload_pkg::*;
#(
    parameter int NB    = 8,
    parameter int AW    = 8,
    parameter int BW    = 3,
    parameter int RW    = 5,
    parameter int TW    = 4,
    parameter int CW    = 5,
    parameter int MAXVL = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [1:0]          mode,
    input  logic [AW-1:0]       base,
    input  logic [AW-1:0]       stride,
    input  logic [CW-1:0]       len,
    input  logic [MAXVL*AW-1:0] index_list,
    input  logic [NB-1:0]       bank_ready,
    output logic [NB-1:0]       issue_vec,
    output logic [RW-1:0]       issue_row,
    output logic [TW-1:0]       issue_tag
);

    logic          gather_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] step_q;
    logic [AW-1:0] acc_q;
    logic [CW-1:0] len_q;
    logic [CW-1:0] ei_q;
    logic [AW-1:0] idx_q [MAXVL];

    logic [AW-1:0] addr;
    logic [BW-1:0] tbank;
    logic          pending;
    logic          go;

    // Address of the element waiting to issue.
    always_comb begin
        if (gather_q) begin
            addr = base_q + idx_q[ei_q[TW-1:0]];
        end else begin
            addr = acc_q;
        end
    end

    assign tbank     = addr[BW-1:0];
    assign pending   = (ei_q < len_q);
    assign go        = pending && bank_ready[tbank];
    assign issue_row = addr[AW-1:BW];
    assign issue_tag = ei_q[TW-1:0];

    // One-hot issue strobe toward the selected bank.
    always_comb begin
        issue_vec = '0;
        if (go) begin
            issue_vec[tbank] = 1'b1;
        end
    end

    // Request capture and advance of the element pointer and running address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gather_q <= 1'b0;
            base_q   <= '0;
            step_q   <= '0;
            acc_q    <= '0;
            len_q    <= '0;
            ei_q     <= '0;
        end else if (accept) begin
            gather_q <= (vmode_e'(mode) == VM_GATHER);
            base_q   <= base;
            step_q   <= (vmode_e'(mode) == VM_STRIDE) ? stride : AW'(1);
            acc_q    <= base;
            len_q    <= len;
            ei_q     <= '0;
        end else if (go) begin
            ei_q  <= ei_q + CW'(1);
            acc_q <= acc_q + step_q;
        end
    end

    // Offset list snapshot taken with the request.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int k = 0; k < MAXVL; k++) begin
                idx_q[k] <= index_list[k*AW +: AW];
            end
        end
    end

endmodule

// File: rtl/vload_reorder.sv
// Result collector. Bank returns are parked in slots indexed by element
// number; the slot for the next expected element, or a return carrying
// that element this cycle, is sent out, so output order is element order
// whatever order the banks finish in. It also owns the busy/done state.
// Assumes: tags within one request are unique and below len.
module vload_reorder #(
    parameter int NB    = 8,
    parameter int TW    = 4,
    parameter int CW    = 5,
    parameter int DW    = 16,
    parameter int MAXVL = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic [CW-1:0]          len,
    input  logic [NB-1:0]          ret_valid,
    input  logic [NB-1:0][TW-1:0]  ret_tag,
    input  logic [NB-1:0][DW-1:0]  ret_data,
    output logic                   busy,
    output logic                   out_valid,
    output logic [TW-1:0]          out_idx,
    output logic [DW-1:0]          out_data,
    output logic                   done
);

    logic [DW-1:0]    slot_q [MAXVL];
    logic [MAXVL-1:0] full_q;
    logic [CW-1:0]    ptr_q;
    logic [CW-1:0]    len_q;
    logic             active_q;

    logic          byp_hit;
    logic [DW-1:0] byp_data;
    logic          slot_hit;
    logic          more;
    logic          last;
    logic          emit;

    // Look for the expected element among this cycle's bank returns.
    always_comb begin
        byp_hit  = 1'b0;
        byp_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (ret_valid[b] && (ret_tag[b] == ptr_q[TW-1:0])) begin
                byp_hit  = 1'b1;
                byp_data = ret_data[b];
            end
        end
    end

    assign slot_hit = full_q[ptr_q[TW-1:0]];
    assign more     = (ptr_q < len_q);
    assign last     = ((ptr_q + CW'(1)) == len_q);
    assign emit     = active_q && more && (slot_hit || byp_hit);
    assign busy     = active_q;

    // Park every bank return in its element slot.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (ret_valid[b]) begin
                slot_q[ret_tag[b]] <= ret_data[b];
            end
        end
    end

    // Sequencing of the in-order output, slot occupancy and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q    <= '0;
            ptr_q     <= '0;
            len_q     <= '0;
            active_q  <= 1'b0;
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_data  <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            if (accept) begin
                active_q <= 1'b1;
                ptr_q    <= '0;
                len_q    <= len;
                full_q   <= '0;
            end else if (active_q) begin
                for (int b = 0; b < NB; b++) begin
                    if (ret_valid[b]) begin
                        full_q[ret_tag[b]] <= 1'b1;
                    end
                end
                if (emit) begin
                    out_valid              <= 1'b1;
                    out_idx                <= ptr_q[TW-1:0];
                    out_data               <= slot_hit ? slot_q[ptr_q[TW-1:0]] : byp_data;
                    full_q[ptr_q[TW-1:0]]  <= 1'b0;
                    ptr_q                  <= ptr_q + CW'(1);
                    if (last) begin
                        done     <= 1'b1;
                        active_q <= 1'b0;
                    end
                end else if (!more) begin
                    done     <= 1'b1;
                    active_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/banked_vload.sv
// Top of the banked vector load unit: address generator, NB interleaved
// unpipelined banks chosen by the low address bits, and the in-order
// result collector.
// Assumes: NB is a power of two, AW > $clog2(NB), MAXVL >= 2.
module banked_vload
    import vload_pkg::*;
#(
    parameter int NB    = 8,
    parameter int LAT   = 6,
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int MAXVL = 16,
    localparam int CW   = $clog2(MAXVL + 1),
    localparam int TW   = $clog2(MAXVL)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode,
    input  logic [AW-1:0]       base,
    input  logic [AW-1:0]       stride,
    input  logic [CW-1:0]       len,
    input  logic [MAXVL*AW-1:0] index_list,
    output logic                busy,
    output logic                out_valid,
    output logic [TW-1:0]       out_idx,
    output logic [DW-1:0]       out_data,
    output logic                done
);

    localparam int BW = $clog2(NB);
    localparam int RW = AW - BW;

    logic                  accept;
    logic [NB-1:0]         bank_ready;
    logic [NB-1:0]         issue_vec;
    logic [RW-1:0]         issue_row;
    logic [TW-1:0]         issue_tag;
    logic [NB-1:0]         ret_valid;
    logic [NB-1:0][TW-1:0] ret_tag;
    logic [NB-1:0][DW-1:0] ret_data;

    // A request is taken only when the unit is idle.
    assign accept = start && !busy;

    vload_agen #(
        .NB(NB), .AW(AW), .BW(BW), .RW(RW), .TW(TW), .CW(CW), .MAXVL(MAXVL)
    ) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .mode       (mode),
        .base       (base),
        .stride     (stride),
        .len        (len),
        .index_list (index_list),
        .bank_ready (bank_ready),
        .issue_vec  (issue_vec),
        .issue_row  (issue_row),
        .issue_tag  (issue_tag)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        vload_bank #(
            .LAT(LAT), .BW(BW), .RW(RW), .DW(DW), .TW(TW), .BANK_ID(g)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue     (issue_vec[g]),
            .row       (issue_row),
            .tag_in    (issue_tag),
            .ready     (bank_ready[g]),
            .ret_valid (ret_valid[g]),
            .ret_tag   (ret_tag[g]),
            .ret_data  (ret_data[g])
        );
    end

    vload_reorder #(
        .NB(NB), .TW(TW), .CW(CW), .DW(DW), .MAXVL(MAXVL)
    ) u_reorder (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .len       (len),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .ret_data  (ret_data),
        .busy      (busy),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_data  (out_data),
        .done      (done)
    );

endmodule

// File: rtl/banked_vload_chk.sv
// Protocol checker for banked_vload, attached by bind. It watches the
// request handshake, the issue strobes against bank readiness, output
// ordering and the completion pulse.
// Assumes: same NB and MAXVL as the bound instance.
module banked_vload_chk #(
    parameter int NB = 8,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          out_valid,
    input logic [TW-1:0] out_idx,
    input logic          done,
    input logic [NB-1:0] issue_vec,
    input logic [NB-1:0] bank_ready
);

    logic [TW:0] seen_q;

    // Number of outputs delivered since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (start && !busy) begin
            seen_q <= '0;
        end else if (out_valid) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("accepted request did not raise busy");

    // R7
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_vec) <= 1)
        else $error("more than one bank issued in a cycle");

    // R7
    issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vec & ~bank_ready) == '0)
        else $error("issue to a bank that is still occupied");

    // R10
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx == seen_q[TW-1:0]))
        else $error("element delivered out of order");

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("busy still high while done");

    // R1
    valid_in_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |-> busy)
        else $error("output outside a request");

endmodule

bind banked_vload banked_vload_chk #(.NB(NB), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_idx    (out_idx),
    .done       (done),
    .issue_vec  (issue_vec),
    .bank_ready (bank_ready)
);

// File: tb/banked_vload_tb.sv
// Bench for banked_vload: a behavioural schedule of bank free times gives
// the expected output of every cycle, which is compared after each edge.
module banked_vload_tb;

    localparam int NB    = 8;
    localparam int LAT   = 6;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int MAXVL = 16;
    localparam int CW    = $clog2(MAXVL + 1);
    localparam int TW    = $clog2(MAXVL);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [1:0]          mode = '0;
    logic [AW-1:0]       base = '0;
    logic [AW-1:0]       stride = '0;
    logic [CW-1:0]       len = '0;
    logic [MAXVL*AW-1:0] index_list = '0;
    logic                busy;
    logic                out_valid;
    logic [TW-1:0]       out_idx;
    logic [DW-1:0]       out_data;
    logic                done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int idxv [MAXVL];
    int first_out;
    int last_out;

    // 4 time-unit period: 250 MHz with nanosecond units.
    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    banked_vload #(
        .NB(NB), .LAT(LAT), .AW(AW), .DW(DW), .MAXVL(MAXVL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
        .stride(stride), .len(len), .index_list(index_list), .busy(busy),
        .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one request and compare every cycle until two cycles after done.
    task automatic run_req(input int md, input int bs, input int st, input int n,
                           input string rq, input bit poke);
        int addr [MAXVL];
        int ocyc [MAXVL];
        int bfree [NB];
        int prev_i;
        int iss;
        int donek;
        int b;
        int hit;
        int expd;
        prev_i = 0;
        for (int j = 0; j < NB; j++) bfree[j] = 0;
        for (int i = 0; i < n; i++) begin
            if (md == 1)      addr[i] = (bs + i * st) % 256;
            else if (md == 2) addr[i] = (bs + idxv[i]) % 256;
            else              addr[i] = (bs + i) % 256;
            b = addr[i] % NB;
            iss = (prev_i + 1 > bfree[b]) ? prev_i + 1 : bfree[b];
            bfree[b] = iss + LAT;
            prev_i = iss;
            ocyc[i] = iss + LAT + 1;
        end
        donek = (n == 0) ? 1 : ocyc[n-1];

        @(negedge clk);
        for (int i = 0; i < MAXVL; i++) index_list[i*AW +: AW] = AW'(idxv[i]);
        start  = 1'b1;
        mode   = 2'(md);
        base   = AW'(bs);
        stride = AW'(st);
        len    = CW'(n);
        @(posedge clk);
        #1;
        start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after accept", int'(busy), 1);
        first_out = -1;
        last_out  = -1;
        for (int k = 1; k <= donek + 2; k++) begin
            @(posedge clk);
            #1;
            hit = -1;
            for (int i = 0; i < n; i++) if (ocyc[i] == k) hit = i;
            chk(out_valid === (hit >= 0), {"R7 ", rq}, "out_valid timing",
                int'(out_valid), int'(hit >= 0));
            if (hit >= 0 && out_valid === 1'b1) begin
                expd = (addr[hit] * 40503 + 4660) % 65536;
                chk(int'(out_idx) == hit, "R10", "element number", int'(out_idx), hit);
                chk(int'(out_data) == expd, {"R3 ", rq}, "element word", int'(out_data), expd);
            end
            if (out_valid === 1'b1) begin
                if (first_out < 0) first_out = k;
                last_out = k;
            end
            chk(done === (k == donek), "R11", "done pulse", int'(done), int'(k == donek));
            chk(busy === (k < donek), "R11", "busy level", int'(busy), int'(k < donek));
            if (poke && k == 2) begin
                start  = 1'b1;
                mode   = 2'd1;
                base   = 8'hA0;
                stride = 8'd5;
                len    = CW'(3);
            end
            if (poke && k == 3) start = 1'b0;
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        wait (cyc >= 60000);
        n_fail++;
        n_checks++;
        $display("FAIL R7 watchdog: actual=%0d expected=<%0d", cyc, 60000);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAXVL; i++) idxv[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R1", "outputs in reset",
            int'({busy, out_valid, done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(busy === 1'b0 && out_valid === 1'b0 && done === 1'b0, "R1", "outputs after reset",
            int'({busy, out_valid, done}), 0);

        // R4 / R8: consecutive words, stride input deliberately nonzero.
        run_req(0, 16, 3, 16, "R4", 1'b0);
        chk(first_out == LAT + 2, "R8", "startup cycles", first_out, LAT + 2);
        chk(last_out - first_out == 15, "R8", "gap-free span", last_out - first_out, 15);

        // R5 / R9: odd step, wrapping past the top of the address space.
        run_req(1, 200, 37, 16, "R5", 1'b0);
        chk(last_out - first_out == 15, "R9", "odd step span", last_out - first_out, 15);

        // R9: step 2 touches half the banks and stalls.
        run_req(1, 3, 2, 12, "R9", 1'b0);
        chk(last_out - first_out > 11, "R9", "step 2 has gaps", last_out - first_out, 12);

        // R9: step 8 hits one bank every time.
        run_req(1, 5, 8, 6, "R9", 1'b0);
        chk(last_out - first_out == 5 * LAT, "R9", "step 8 span", last_out - first_out, 5 * LAT);

        // R6: offset list with bank repeats.
        idxv[0] = 0;  idxv[1] = 8;  idxv[2] = 16; idxv[3] = 1;  idxv[4] = 2;
        idxv[5] = 9;  idxv[6] = 3;  idxv[7] = 3;  idxv[8] = 40; idxv[9] = 7;
        run_req(2, 4, 0, 10, "R6", 1'b0);

        // R6: full-length list reaching the top of memory.
        for (int i = 0; i < MAXVL; i++) idxv[i] = (i * 77 + 250) % 256;
        run_req(2, 9, 0, MAXVL, "R6", 1'b0);

        // R2: a second start during the request is ignored.
        for (int i = 0; i < MAXVL; i++) idxv[i] = 0;
        run_req(0, 100, 0, 9, "R2", 1'b1);

        // R4: the spare mode behaves as consecutive.
        run_req(3, 250, 6, 10, "R4", 1'b0);

        // R12: empty request.
        run_req(0, 0, 0, 0, "R12", 1'b0);
        chk(first_out == -1, "R12", "no output for empty request", first_out, -1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule